// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This block resolves where one instruction operand lives for a small 16-bit processor with a register file. It is given a decoded mode code, a register index and that register's current value, the extension word that follows the opcode, the current program counter and a flag that selects a source or a destination operand. From these it reports one of three operand kinds: a register operand, a memory operand with its effective address, or an immediate value. When the mode post-increments its base register, it also asks for a register write-back.

The unit is purely combinational and sits between the decoder and the operand fetch stage. The fetch logic reads the extension-word flag to decide whether to step the program counter past an extension word. The execute stage uses the other outputs to steer register reads, memory reads or writes, and the write-back port. A source operand can use any of seven modes. A destination operand can use only four, and any other code is reported as an error.

Top module: `opnd_addr_unit`

## Requirements
- R1: Mode code 0 (register) asserts the register-operand flag, returns the input register index as the operand register, and asserts no memory access, no immediate, no write-back and no extension use. The address output reads 0.
- R2: Mode code 1 (indexed) yields a memory operand at register value plus extension word, and it uses the extension word.
- R3: Mode code 2 (symbolic) yields a memory operand at program counter plus extension word, and it uses the extension word.
- R4: Mode code 3 (absolute) yields a memory operand whose address is the extension word, and it uses the extension word.
- R5: Mode code 4 (indirect, source only) yields a memory operand at the register value and does not use the extension word.
- R6: Mode code 5 (indirect with post-increment, source only) yields a memory operand at the register value and requests a write-back to the same register of its value plus 2 for a word operation.
- R7: In mode code 5 with the byte flag set, the write-back value is the register value plus 1, except for register index 0 (program counter) and index 1 (stack pointer), which step by 2.
- R8: Mode code 6 (immediate, source only) sets the immediate-valid flag, drives the extension word on the immediate output, uses the extension word, and asserts no memory access.
- R9: With the destination flag set, mode codes 4, 5 and 6 raise the mode-error flag. Code 7 raises it for either operand. While the error flag is high, every operand, immediate, write-back and extension-use output is low.
- R10: A write-back request occurs only for a source operand in mode code 5. At all other times write-back enable, register and value are 0, and the immediate output is 0 unless R8 applies.
- R11: All address and increment arithmetic wraps modulo 2^16 (for example, 16'hFFFF plus 2 gives 16'h0001).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 3 | Decoded addressing mode code (0..7) |
| is_dst_i | input | 1 | 1 = destination operand, 0 = source operand |
| byte_i | input | 1 | 1 = byte operation, 0 = word operation |
| reg_idx_i | input | RW | Index of the base or operand register |
| reg_val_i | input | DW | Current contents of that register |
| ext_i | input | DW | Extension word from the instruction stream |
| pc_i | input | DW | Current program counter value |
| opnd_is_reg_o | output | 1 | Operand is a register |
| opnd_reg_o | output | RW | Operand register index (register mode), else 0 |
| opnd_is_mem_o | output | 1 | Operand is in memory |
| addr_o | output | DW | Effective memory address, else 0 |
| imm_valid_o | output | 1 | Operand is an immediate value |
| imm_o | output | DW | Immediate value, else 0 |
| wb_en_o | output | 1 | Base register write-back request |
| wb_reg_o | output | RW | Register to write back |
| wb_val_o | output | DW | Incremented register value |
| ext_used_o | output | 1 | Mode consumes an extension word |
| mode_err_o | output | 1 | Illegal mode for this operand |

## Verification
The bench builds the unit with the default parameters: a 16-bit data width and a 4-bit register index. With 16 registers, random indices hit the program counter and stack pointer exceptions to the byte step often enough. With the narrow word, random register values and extension words often wrap past 16'hFFFF. Directed cases add wraparound at the exact boundary and every illegal destination code. A large random batch then covers every mode, operand side and operation width in combination.

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit #(
  parameter int DW     = 16,
  parameter int RW     = 4,
  parameter int PC_IDX = 0,
  parameter int SP_IDX = 1
) (
  input  logic [2:0]    mode_i,
  input  logic          is_dst_i,
  input  logic          byte_i,
  input  logic [RW-1:0] reg_idx_i,
  input  logic [DW-1:0] reg_val_i,
  input  logic [DW-1:0] ext_i,
  input  logic [DW-1:0] pc_i,
  output logic          opnd_is_reg_o,
  output logic [RW-1:0] opnd_reg_o,
  output logic          opnd_is_mem_o,
  output logic [DW-1:0] addr_o,
  output logic          imm_valid_o,
  output logic [DW-1:0] imm_o,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_reg_o,
  output logic [DW-1:0] wb_val_o,
  output logic          ext_used_o,
  output logic          mode_err_o
);
  localparam logic [2:0] M_REG = 3'd0;
  localparam logic [2:0] M_IDX = 3'd1;
  localparam logic [2:0] M_SYM = 3'd2;
  localparam logic [2:0] M_ABS = 3'd3;
  localparam logic [2:0] M_IND = 3'd4;
  localparam logic [2:0] M_INC = 3'd5;
  localparam logic [2:0] M_IMM = 3'd6;

  logic          aligned_reg;
  logic [DW-1:0] step;

  assign aligned_reg = (reg_idx_i == RW'(PC_IDX)) || (reg_idx_i == RW'(SP_IDX));
  assign step        = (byte_i && !aligned_reg) ? DW'(1) : DW'(2);

  always_comb begin
    opnd_is_reg_o = 1'b0;
    opnd_reg_o    = '0;
    opnd_is_mem_o = 1'b0;
    addr_o        = '0;
    imm_valid_o   = 1'b0;
    imm_o         = '0;
    wb_en_o       = 1'b0;
    wb_reg_o      = '0;
    wb_val_o      = '0;
    ext_used_o    = 1'b0;
    mode_err_o    = 1'b0;
    if (is_dst_i && mode_i >= M_IND) begin
      mode_err_o = 1'b1;
    end else begin
      case (mode_i)
        M_REG: begin
          opnd_is_reg_o = 1'b1;
          opnd_reg_o    = reg_idx_i;
        end
        M_IDX: begin
          opnd_is_mem_o = 1'b1;
          addr_o        = reg_val_i + ext_i;
          ext_used_o    = 1'b1;
        end
        M_SYM: begin
          opnd_is_mem_o = 1'b1;
          addr_o        = pc_i + ext_i;
          ext_used_o    = 1'b1;
        end
        M_ABS: begin
          opnd_is_mem_o = 1'b1;
          addr_o        = ext_i;
          ext_used_o    = 1'b1;
        end
        M_IND: begin
          opnd_is_mem_o = 1'b1;
          addr_o        = reg_val_i;
        end
        M_INC: begin
          opnd_is_mem_o = 1'b1;
          addr_o        = reg_val_i;
          wb_en_o       = 1'b1;
          wb_reg_o      = reg_idx_i;
          wb_val_o      = reg_val_i + step;
        end
        M_IMM: begin
          imm_valid_o   = 1'b1;
          imm_o         = ext_i;
          ext_used_o    = 1'b1;
        end
        default: mode_err_o = 1'b1;
      endcase
    end
  end

  always_comb begin
    a_r1_reg_no_mem: assert (!(opnd_is_reg_o && (opnd_is_mem_o || wb_en_o || ext_used_o)))
      else $error("R1: register operand with memory side effect");
    a_r9_err_quiet: assert (!(mode_err_o && (opnd_is_reg_o || opnd_is_mem_o || imm_valid_o || wb_en_o || ext_used_o)))
      else $error("R9: error flag with active outputs");
    a_r10_wb_src_only: assert (!(wb_en_o && is_dst_i))
      else $error("R10: write-back on destination operand");
    a_r8_imm_no_mem: assert (!(imm_valid_o && (opnd_is_mem_o || !ext_used_o)))
      else $error("R8: immediate with memory access");
    a_r7_step_range: assert (!wb_en_o || (wb_val_o - reg_val_i == DW'(1)) || (wb_val_o - reg_val_i == DW'(2)))
      else $error("R7: increment step out of range");
    a_r5_kind_onehot: assert ($onehot0({opnd_is_reg_o, opnd_is_mem_o, imm_valid_o, mode_err_o}))
      else $error("R5: operand kind not one-hot");
  end
endmodule

// File: tb/opnd_addr_unit_tb.sv
module opnd_addr_unit_tb_top;
  localparam int DW = 16;
  localparam int RW = 4;
  localparam int OW = 1 + RW + 1 + DW + 1 + DW + 1 + RW + DW + 1 + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]    mode;
  logic          is_dst, byte_op;
  logic [RW-1:0] ridx;
  logic [DW-1:0] rval, ext, pc;
  logic          o_isreg, o_ismem, o_immv, o_wb, o_ext, o_err;
  logic [RW-1:0] o_reg, o_wbreg;
  logic [DW-1:0] o_addr, o_imm, o_wbval;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  opnd_addr_unit #(.DW(DW), .RW(RW)) dut_i (
    .mode_i(mode), .is_dst_i(is_dst), .byte_i(byte_op), .reg_idx_i(ridx),
    .reg_val_i(rval), .ext_i(ext), .pc_i(pc),
    .opnd_is_reg_o(o_isreg), .opnd_reg_o(o_reg), .opnd_is_mem_o(o_ismem),
    .addr_o(o_addr), .imm_valid_o(o_immv), .imm_o(o_imm), .wb_en_o(o_wb),
    .wb_reg_o(o_wbreg), .wb_val_o(o_wbval), .ext_used_o(o_ext), .mode_err_o(o_err)
  );

  function automatic logic [OW-1:0] model(input logic [2:0] m, input logic d, input logic b,
      input logic [RW-1:0] ri, input logic [DW-1:0] rv, input logic [DW-1:0] e, input logic [DW-1:0] p);
    logic isreg = 0, ismem = 0, immv = 0, wb = 0, ex = 0, er = 0;
    logic [RW-1:0] rg = '0, wr = '0;
    logic [DW-1:0] ad = '0, im = '0, wv = '0;
    logic [DW:0] wide;
    if (m == 3'd7 || (d && m >= 3'd4)) er = 1;
    else if (m == 3'd0) begin isreg = 1; rg = ri; end
    else if (m == 3'd1) begin ismem = 1; ex = 1; wide = {1'b0, rv} + {1'b0, e}; ad = wide[DW-1:0]; end
    else if (m == 3'd2) begin ismem = 1; ex = 1; wide = {1'b0, p} + {1'b0, e}; ad = wide[DW-1:0]; end
    else if (m == 3'd3) begin ismem = 1; ex = 1; ad = e; end
    else if (m == 3'd4) begin ismem = 1; ad = rv; end
    else if (m == 3'd5) begin
      ismem = 1; ad = rv; wb = 1; wr = ri;
      wide = {1'b0, rv} + ((b && ri > 1) ? 17'd1 : 17'd2);
      wv = wide[DW-1:0];
    end
    else begin immv = 1; im = e; ex = 1; end
    return {isreg, rg, ismem, ad, immv, im, wb, wr, wv, ex, er};
  endfunction

  function automatic string tag(input logic [2:0] m, input logic d, input logic b);
    if (m == 3'd7 || (d && m >= 3'd4)) return "R9";
    case (m)
      3'd0: return "R1";
      3'd1: return "R2/R11";
      3'd2: return "R3/R11";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return b ? "R7/R10" : "R6/R11";
      default: return "R8";
    endcase
  endfunction

  task automatic apply_check(input logic [2:0] m, input logic d, input logic b,
      input logic [RW-1:0] ri, input logic [DW-1:0] rv, input logic [DW-1:0] e, input logic [DW-1:0] p);
    logic [OW-1:0] exp, act;
    @(posedge clk);
    #1;
    mode = m; is_dst = d; byte_op = b; ridx = ri; rval = rv; ext = e; pc = p;
    @(negedge clk);
    exp = model(m, d, b, ri, rv, e, p);
    act = {o_isreg, o_reg, o_ismem, o_addr, o_immv, o_imm, o_wb, o_wbreg, o_wbval, o_ext, o_err};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d dst=%0d byte=%0d reg=%0d: actual=%h expected=%h",
               tag(m, d, b), m, d, b, ri, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    // all-zero inputs: R1 register mode on register 0
    apply_check(3'd0, 0, 0, 4'd0, 16'h0000, 16'h0000, 16'h0000);
    // R1 register mode with nonzero operands
    apply_check(3'd0, 1, 0, 4'd9, 16'h1234, 16'hBEEF, 16'h4000);
    // R11 wraps
    apply_check(3'd1, 0, 0, 4'd5, 16'hFFFE, 16'h0004, 16'h0000);
    apply_check(3'd2, 1, 0, 4'd3, 16'h0000, 16'hFFF0, 16'h0020);
    apply_check(3'd5, 0, 0, 4'd7, 16'hFFFF, 16'h0000, 16'h0000);
    // R4, R5, R8 directed
    apply_check(3'd3, 1, 0, 4'd2, 16'h1111, 16'h0200, 16'h8000);
    apply_check(3'd4, 0, 1, 4'd6, 16'h0A0A, 16'h5555, 16'h0000);
    apply_check(3'd6, 0, 0, 4'd4, 16'h0000, 16'h002D, 16'h0100);
    // R7 byte step: general reg, PC, SP
    apply_check(3'd5, 0, 1, 4'd10, 16'h0100, 16'h0000, 16'h0000);
    apply_check(3'd5, 0, 1, 4'd0,  16'h0100, 16'h0000, 16'h0000);
    apply_check(3'd5, 0, 1, 4'd1,  16'h0100, 16'h0000, 16'h0000);
    apply_check(3'd5, 0, 1, 4'd15, 16'hFFFF, 16'h0000, 16'h0000);
    // R9 illegal destination codes and code 7
    for (int m = 4; m < 8; m++) apply_check(3'(m), 1, 0, 4'd8, 16'h2222, 16'h3333, 16'h4444);
    apply_check(3'd7, 0, 1, 4'd8, 16'h2222, 16'h3333, 16'h4444);
    // R10 constrained random
    for (int i = 0; i < 3000; i++)
      apply_check(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom), 4'($urandom),
                  16'($urandom), 16'($urandom), 16'($urandom));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule